// File: doc/BRIEF.md
# Gate Driver Enable and Fault-Reset Sequencer

This controller sits beside a three-phase gate-driver core and turns one asynchronous enable pin into power-state commands for the regulator, the charge pump, the current-sense amplifiers and the gate-output stage. It also latches fault flags. The time the enable pin stays low selects the action. A short low pulse is a quick fault reset: the supplies stay up and the gate stage comes straight back. A long low period is a full reset: every subsystem shuts down and a complete ordered power-up runs when the pin returns high. A low pulse whose length falls between the two windows is illegal. It sets a sticky misuse flag and is then handled as a full reset.

Faults on the gate path are latched from live condition inputs. They clear on any rising edge of the enable pin, but a condition that is still asserted at that edge stays latched. The gate-supply overvoltage flag clears only after a long low period. All times are counted in clock cycles and set by parameters. The pin passes through a two-flop synchronizer.

Top module: `gate_enable_seq`

## Requirements
- R1: The enable pin is synchronized by two flops. `gate_en` drops in the first cycle in which the synchronized enable reads low, which is two clock edges after the pin falls. `gate_hiz` is always the inverse of `gate_en`.
- R2: After the synchronized enable goes low, `reg_en`, `cp_en` and `amp_en` stay high for exactly T_QUICK cycles and are all low from the next cycle on, for as long as the enable stays low.
- R3: When the synchronized enable is low for fewer than T_QUICK cycles while the block is running, the supplies never drop. `gate_en` and `ready` return in the cycle after the synchronized rising edge is seen.
- R4: Power-up runs in a fixed order. `reg_en` comes first, then `cp_en`, then `amp_en`, with T_SETTLE cycles between steps. `ready` and the gate stage come T_SETTLE cycles after `amp_en`.
- R5: On each synchronized rising edge, every bit of `flt_latch` is cleared unless its `flt_cond` bit is high in that cycle.
- R6: A high `flt_cond` bit sets its `flt_latch` bit one cycle later. While any `flt_latch` bit or `ovp_latch` is set, `gate_en` is low and `gate_hiz` is high, even when the enable is high.
- R7: `ovp_latch` is set one cycle after `ovp_cond` is high. It clears on a rising edge only when the preceding low period was longer than T_FULL cycles.
- R8: A low period of at least T_QUICK and at most T_FULL cycles sets `misuse`, which only reset clears. It is followed by the full power-up sequence, and `ovp_latch` is kept.
- R9: While reset is asserted, all enables, `ready`, `misuse` and both latches are low and `gate_hiz` is high. The first rising edge after reset runs the full power-up.
- R10: If the enable drops during power-up, all supplies switch off in the next cycle. The next rising edge restarts the full power-up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_pin | input | 1 | Asynchronous enable pin |
| flt_cond | input | NFLT | Live gate-path fault conditions |
| ovp_cond | input | 1 | Live gate-supply overvoltage condition |
| reg_en | output | 1 | Regulator enable |
| cp_en | output | 1 | Charge pump enable |
| amp_en | output | 1 | Current-sense amplifier enable |
| gate_en | output | 1 | Gate-output stage enable |
| gate_hiz | output | 1 | Gate outputs high impedance |
| flt_latch | output | NFLT | Latched gate-path faults |
| ovp_latch | output | 1 | Latched overvoltage fault |
| ready | output | 1 | Power-up complete and gate stage sequenced in |
| misuse | output | 1 | Sticky forbidden-pulse flag |

## Verification
Two situations are hard to reach from the ports. The first is a low pulse that ends inside the forbidden band while an overvoltage fault is latched: the bench drives a pulse of 30 cycles between windows of 20 and 40 and then checks that `ovp_latch` survives the following full power-up. The second is a rising edge that arrives while a fault condition is still active. The bench holds one `flt_cond` bit high across a quick pulse, and it also drops the enable in the middle of power-up to reach the abort path.

// File: rtl/gate_enable_seq.sv
module gate_enable_seq #(
  parameter int T_QUICK  = 500,
  parameter int T_FULL   = 1000,
  parameter int T_SETTLE = 50,
  parameter int NFLT     = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en_pin,
  input  logic [NFLT-1:0] flt_cond,
  input  logic            ovp_cond,
  output logic            reg_en,
  output logic            cp_en,
  output logic            amp_en,
  output logic            gate_en,
  output logic            gate_hiz,
  output logic [NFLT-1:0] flt_latch,
  output logic            ovp_latch,
  output logic            ready,
  output logic            misuse
);
  localparam int LW = $clog2(T_FULL + 2);
  localparam int CW = (T_SETTLE > 1) ? $clog2(T_SETTLE) : 1;
  localparam logic [LW-1:0] LSAT = LW'(T_FULL + 1);
  localparam logic [LW-1:0] LQ   = LW'(T_QUICK);
  localparam logic [LW-1:0] LQ1  = LW'(T_QUICK - 1);
  localparam logic [LW-1:0] LF   = LW'(T_FULL);
  localparam logic [CW-1:0] CS   = CW'(T_SETTLE - 1);

  typedef enum logic [2:0] {S_OFF, S_REG, S_CP, S_AMP, S_RUN, S_HOLD} st_t;

  st_t st, st_n;
  logic s1, en_s, en_q;
  logic [LW-1:0] lo_cnt;
  logic [CW-1:0] cnt;

  wire rise    = en_s & ~en_q;
  wire pwrup   = (st == S_REG) || (st == S_CP) || (st == S_AMP);
  wire band    = (lo_cnt >= LQ) && (lo_cnt <= LF);
  wire any_flt = (|flt_latch) | ovp_latch;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) {s1, en_s, en_q} <= '0;
    else        {s1, en_s, en_q} <= {en_pin, s1, en_s};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)     lo_cnt <= LSAT;
    else if (en_s)  lo_cnt <= '0;
    else if (lo_cnt != LSAT) lo_cnt <= lo_cnt + 1'b1;

  always_comb begin
    st_n = st;
    if (!en_s) begin
      if (st != S_OFF && lo_cnt >= LQ1) st_n = S_OFF;
      else if (st == S_RUN)             st_n = S_HOLD;
      else if (pwrup)                   st_n = S_OFF;
    end else if (rise) begin
      st_n = (st == S_HOLD) ? S_RUN : S_REG;
    end else if (cnt == CS) begin
      case (st)
        S_REG:   st_n = S_CP;
        S_CP:    st_n = S_AMP;
        S_AMP:   st_n = S_RUN;
        default: st_n = st;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st  <= S_OFF;
      cnt <= '0;
    end else begin
      st <= st_n;
      if (st_n != st)  cnt <= '0;
      else if (cnt != CS) cnt <= cnt + 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      flt_latch <= '0;
      ovp_latch <= 1'b0;
      misuse    <= 1'b0;
    end else if (rise) begin
      flt_latch <= flt_cond;
      ovp_latch <= (lo_cnt > LF) ? ovp_cond : (ovp_latch | ovp_cond);
      if (band) misuse <= 1'b1;
    end else begin
      flt_latch <= flt_latch | flt_cond;
      ovp_latch <= ovp_latch | ovp_cond;
    end

  assign reg_en   = (st != S_OFF);
  assign cp_en    = (st == S_CP) || (st == S_AMP) || (st == S_RUN) || (st == S_HOLD);
  assign amp_en   = (st == S_AMP) || (st == S_RUN) || (st == S_HOLD);
  assign ready    = (st == S_RUN);
  assign gate_en  = ready & en_s & ~any_flt;
  assign gate_hiz = ~gate_en;

  // R4
  power_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(amp_en) |-> (cp_en && reg_en));
  // R4
  ready_after_amp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> amp_en);
  // R5
  live_fault_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> ((flt_latch & $past(flt_cond)) == $past(flt_cond)));
  // R7
  ovp_quick_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && lo_cnt < LQ && ovp_latch) |=> ovp_latch);
  // R8
  misuse_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    misuse |=> misuse);
  // R2
  supply_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_s && lo_cnt == LQ1) |=> !reg_en);
  // R6
  fault_blocks_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|flt_cond) |=> gate_hiz);
endmodule

// File: tb/tb_gate_enable_seq.sv
module tb_gate_enable_seq;
  localparam int TQ = 20, TF = 40, TS = 4, NF = 4;
  logic clk = 0, rst_n = 0, en_pin = 0, ovp_cond = 0;
  logic [NF-1:0] flt_cond = '0;
  logic reg_en, cp_en, amp_en, gate_en, gate_hiz, ovp_latch, ready, misuse;
  logic [NF-1:0] flt_latch;
  int total = 0, bad = 0, cyc = 0;
  string cur_req = "R9";
  bit done = 0;

  gate_enable_seq #(.T_QUICK(TQ), .T_FULL(TF), .T_SETTLE(TS), .NFLT(NF)) dut (
    .clk, .rst_n, .en_pin, .flt_cond, .ovp_cond, .reg_en, .cp_en, .amp_en,
    .gate_en, .gate_hiz, .flt_latch, .ovp_latch, .ready, .misuse);

  always #10 clk = ~clk;

  // reference model: phase 0 off,1 reg,2 cp,3 amp,4 run,5 hold
  int m_s1, m_s2, m_prev, m_low, m_ph, m_cnt, m_ovp, m_mis;
  logic [NF-1:0] m_flt;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_s1 = 0; m_s2 = 0; m_prev = 0; m_low = TF + 1; m_ph = 0; m_cnt = 0;
      m_flt = '0; m_ovp = 0; m_mis = 0;
    end else begin
      int nph, rise;
      rise = (m_s2 == 1 && m_prev == 0);
      nph = m_ph;
      if (m_s2 == 0) begin
        if (m_ph != 0 && m_low >= TQ - 1) nph = 0;
        else if (m_ph == 4) nph = 5;
        else if (m_ph >= 1 && m_ph <= 3) nph = 0;
      end else if (rise) nph = (m_ph == 5) ? 4 : 1;
      else if (m_ph >= 1 && m_ph <= 3 && m_cnt == TS - 1) nph = m_ph + 1;
      if (rise) begin
        if (m_low >= TQ && m_low <= TF) m_mis = 1;
        m_ovp = (m_low > TF) ? int'(ovp_cond) : (m_ovp | int'(ovp_cond));
        m_flt = flt_cond;
      end else begin
        m_flt = m_flt | flt_cond;
        m_ovp = m_ovp | int'(ovp_cond);
      end
      if (nph != m_ph) m_cnt = 0; else if (m_cnt < TS - 1) m_cnt++;
      m_ph = nph;
      m_low = m_s2 ? 0 : ((m_low < TF + 1) ? m_low + 1 : m_low);
      m_prev = m_s2; m_s2 = m_s1; m_s1 = int'(en_pin);
    end
  end

  task automatic chk(bit ok, string req, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    int e_reg, e_cp, e_amp, e_rdy, e_gate;
    e_reg = (m_ph != 0); e_cp = (m_ph >= 2); e_amp = (m_ph >= 3);
    e_rdy = (m_ph == 4);
    e_gate = (e_rdy && m_s2 == 1 && m_flt == 0 && m_ovp == 0);
    chk(reg_en == e_reg, cur_req, "reg_en", reg_en, e_reg);
    chk(cp_en == e_cp, cur_req, "cp_en", cp_en, e_cp);
    chk(amp_en == e_amp, cur_req, "amp_en", amp_en, e_amp);
    chk(ready == e_rdy, cur_req, "ready", ready, e_rdy);
    chk(gate_en == e_gate, cur_req, "gate_en", gate_en, e_gate);
    chk(gate_hiz == !e_gate, "R1", "gate_hiz", gate_hiz, !e_gate);
    chk(flt_latch == m_flt, cur_req, "flt_latch", flt_latch, m_flt);
    chk(ovp_latch == m_ovp, cur_req, "ovp_latch", ovp_latch, m_ovp);
    chk(misuse == m_mis, cur_req, "misuse", misuse, m_mis);
  end

  task automatic low_for(int n);
    en_pin = 0;
    repeat (n) @(negedge clk);
    en_pin = 1;
  endtask

  task automatic finish_run();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      chk(0, "watchdog", "timeout", cyc, 20000);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(reg_en == 0 && cp_en == 0 && amp_en == 0 && ready == 0, "R9", "supplies", reg_en, 0);
    chk(gate_hiz == 1 && misuse == 0 && flt_latch == 0 && ovp_latch == 0, "R9", "flags", gate_hiz, 1);
    en_pin = 1; rst_n = 1;
    cur_req = "R4";
    repeat (25) @(negedge clk);
    chk(ready == 1 && gate_en == 1, "R4", "ready after power-up", ready, 1);

    cur_req = "R6";
    flt_cond = 4'b0001; @(negedge clk); flt_cond = 0;
    repeat (3) @(negedge clk);
    chk(flt_latch == 4'b0001 && gate_hiz == 1, "R6", "fault latched, gate hiz", flt_latch, 1);

    cur_req = "R3";
    low_for(5);
    repeat (10) @(negedge clk);
    chk(flt_latch == 0, "R5", "fault cleared by quick", flt_latch, 0);
    chk(gate_en == 1 && reg_en == 1, "R3", "gate back after quick", gate_en, 1);

    cur_req = "R5";
    flt_cond = 4'b0010;
    repeat (2) @(negedge clk);
    low_for(5);
    repeat (6) @(negedge clk);
    chk(flt_latch == 4'b0010, "R5", "live fault kept", flt_latch, 2);
    flt_cond = 0;
    low_for(5);
    repeat (6) @(negedge clk);
    chk(flt_latch == 0, "R5", "fault cleared once gone", flt_latch, 0);

    cur_req = "R7";
    ovp_cond = 1; @(negedge clk); ovp_cond = 0;
    low_for(5);
    repeat (6) @(negedge clk);
    chk(ovp_latch == 1, "R7", "ovp kept after quick", ovp_latch, 1);

    cur_req = "R8";
    low_for(30);
    repeat (25) @(negedge clk);
    chk(misuse == 1, "R8", "misuse set", misuse, 1);
    chk(ovp_latch == 1, "R8", "ovp kept after band pulse", ovp_latch, 1);
    chk(ready == 1, "R8", "full power-up after band pulse", ready, 1);

    cur_req = "R2";
    en_pin = 0;
    repeat (30) @(negedge clk);
    chk(reg_en == 0 && cp_en == 0 && amp_en == 0, "R2", "supplies off in long low", reg_en, 0);
    repeat (30) @(negedge clk);
    en_pin = 1;
    cur_req = "R7";
    repeat (25) @(negedge clk);
    chk(ovp_latch == 0, "R7", "ovp cleared by full", ovp_latch, 0);
    chk(ready == 1 && gate_en == 1, "R7", "running after full", ready, 1);

    cur_req = "R10";
    low_for(60);
    repeat (8) @(negedge clk);
    low_for(3);
    chk(ready == 0, "R10", "aborted power-up", ready, 0);
    repeat (25) @(negedge clk);
    chk(ready == 1, "R10", "restart after abort", ready, 1);

    cur_req = "R1";
    en_pin = 0;
    @(negedge clk);
    chk(gate_en == 1, "R1", "gate before sync", gate_en, 1);
    @(negedge clk);
    chk(gate_en == 0 && gate_hiz == 1, "R1", "gate off at sync low", gate_en, 0);
    en_pin = 1;
    repeat (10) @(negedge clk);
    finish_run();
  end
endmodule